// File: doc/BRIEF.md
# Wait/Hold Count Clock Divider

This block divides a domain clock by an integer ratio. The ratio comes from two counts. A wait count sets how many input cycles the output spends high, and a hold count sets how many it spends low. The output period is wait + hold + 2 input cycles. A single 32-bit configuration word holds both counts, a bypass control and an apply request. The word can be written in one cycle and read back at any time.

Software writes new counts together with the apply bit. The apply bit then reads 1 until the divider has adopted the counts. The divider adopts them only when a low phase ends, so a period is never cut short. Setting the bypass control routes the raw input clock to the output. The path select changes only on a falling input edge while the divided clock is low. A parameter selects a narrow variant in which each count is 3 bits wide instead of 4.

Top module: `wait_hold_divider`

## Requirements
- R1: With active counts W and H and bypass off, the output stays high for exactly W+1 input cycles and low for exactly H+1 input cycles, giving a period of W+H+2 cycles. Odd ratios therefore carry the extra cycle in the low phase when W = R/2-1.
- R2: The configuration word holds the wait count in bits [19:16] and the hold count in bits [23:20]. Reading the word returns the last written counts in those same bit positions.
- R3: When bit 24 of the word is 1, the output follows the input clock: high in the high half of each input cycle and low in the low half. Bit 24 reads back as written.
- R4: The bypass path select changes only on a falling input edge at which the divided clock is low.
- R5: A write with bit 25 set makes bit 25 read 1 from the next cycle on. Bit 25 then reads 0 once the new counts have been adopted.
- R6: Written counts become active only at the end of a low phase, and only when bit 25 was set. A write with bit 25 clear leaves the output period unchanged.
- R7: After reset, the word reads all zeros and the divider runs at divide-by-2 (one cycle high, one cycle low) with bypass off.
- R8: The largest counts give the largest ratio, 2^(CNT_W+1): 32 for 4-bit fields and 16 for the narrow variant. In the narrow variant, bits 19 and 23 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Domain clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 32 | Configuration word to write |
| cfgRdData | output | 32 | Configuration word readback with apply status |
| clkOut | output | 1 | Divided or bypassed output clock |

## Verification
The embedded properties watch four things on every edge. The phase counter stays within the active count for its phase. Active counts move only on a low-to-high boundary. The apply flag rises after an apply write and drops only at a period end. The bypass select switches only while the divided clock is low. Only the bench's scenarios can show the actual high and low durations at the pin. The same holds for the effect of writes without the apply bit, the field masking of the narrow variant, and the raw-clock shape of the output in bypass.

// File: rtl/whdiv_pkg.sv
package whdiv_pkg;
  localparam int CFG_W     = 32;
  localparam int FIELD_MAX = 4;
  localparam int WAIT_LSB  = 16;
  localparam int HOLD_LSB  = 20;
  localparam int BYP_BIT   = 24;
  localparam int APPLY_BIT = 25;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic [FIELD_MAX-1:0] waitVal;
    logic [FIELD_MAX-1:0] holdVal;
  } divCmd_t;
endpackage

// File: rtl/whdiv_dp.sv
module whdiv_dp
  import whdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic    clkIn,
  input  logic    rstN,
  input  divCmd_t cmd,
  output logic    divOut,
  output logic    periodEnd
);
  logic [CNT_W-1:0] actWait;
  logic [CNT_W-1:0] actHold;
  logic [CNT_W-1:0] phaseCnt;
  logic lowDone;
  logic highDone;

  assign lowDone   = !divOut && (phaseCnt == actHold);
  assign highDone  = divOut && (phaseCnt == actWait);
  assign periodEnd = lowDone;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      divOut   <= 1'b0;
      phaseCnt <= '0;
      actWait  <= '0;
      actHold  <= '0;
    end else if (lowDone) begin
      divOut   <= 1'b1;
      phaseCnt <= '0;
      if (cmd.load) begin
        actWait <= cmd.waitVal[CNT_W-1:0];
        actHold <= cmd.holdVal[CNT_W-1:0];
      end
    end else if (highDone) begin
      divOut   <= 1'b0;
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // R1
  cnt_high_range_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    divOut |-> (phaseCnt <= actWait));
  // R1
  cnt_low_range_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    !divOut |-> (phaseCnt <= actHold));
  // R6
  counts_at_boundary_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (!$stable(actWait) || !$stable(actHold)) |-> $rose(divOut));
endmodule

// File: rtl/whdiv_ctrl.sv
module whdiv_ctrl
  import whdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             periodEnd,
  input  logic             divOut,
  output divCmd_t          cmd,
  output logic             bypassSel,
  output logic [CFG_W-1:0] cfgRdData
);
  logic [CNT_W-1:0] shWait;
  logic [CNT_W-1:0] shHold;
  logic bypassReq;
  logic pending;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      shWait    <= '0;
      shHold    <= '0;
      bypassReq <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        shWait    <= cfgWrData[WAIT_LSB +: CNT_W];
        shHold    <= cfgWrData[HOLD_LSB +: CNT_W];
        bypassReq <= cfgWrData[BYP_BIT];
      end
      if (cfgWrEn && cfgWrData[APPLY_BIT]) pending <= 1'b1;
      else if (cmd.load)                   pending <= 1'b0;
    end
  end

  // path select moves on the falling edge, only while the divided clock is low
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN)        bypassSel <= 1'b0;
    else if (!divOut) bypassSel <= bypassReq;
  end

  always_comb begin
    cmd         = '0;
    cmd.load    = periodEnd && pending;
    cmd.waitVal[CNT_W-1:0] = shWait;
    cmd.holdVal[CNT_W-1:0] = shHold;
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[WAIT_LSB +: CNT_W] = shWait;
    cfgRdData[HOLD_LSB +: CNT_W] = shHold;
    cfgRdData[BYP_BIT]   = bypassReq;
    cfgRdData[APPLY_BIT] = pending;
  end

  // R5
  apply_sets_pending_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (cfgWrEn && cfgWrData[APPLY_BIT]) |=> pending);
  // R6
  pending_clear_at_end_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $fell(pending) |-> $past(periodEnd));
  // R4
  bypass_switch_low_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    !$stable(bypassSel) |-> $past(!divOut));
endmodule

// File: rtl/wait_hold_divider.sv
module wait_hold_divider
  import whdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clkIn,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        clkOut
);
  divCmd_t cmd;
  logic divOut;
  logic periodEnd;
  logic bypassSel;

  whdiv_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clkIn(clkIn), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .periodEnd(periodEnd), .divOut(divOut), .cmd(cmd),
    .bypassSel(bypassSel), .cfgRdData(cfgRdData)
  );

  whdiv_dp #(.CNT_W(CNT_W)) uDp (
    .clkIn(clkIn), .rstN(rstN), .cmd(cmd),
    .divOut(divOut), .periodEnd(periodEnd)
  );

  assign clkOut = bypassSel ? clkIn : divOut;
endmodule

// File: tb/tb_wait_hold_divider.sv
module tb_wait_hold_divider;
  logic clkIn = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] rdM, rdN;
  logic outM, outN;
  int total = 0;
  int fails = 0;

  always #10 clkIn = ~clkIn;

  wait_hold_divider #(.CNT_W(4)) dut (
    .clkIn(clkIn), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(rdM), .clkOut(outM));
  wait_hold_divider #(.CNT_W(3)) dutNarrow (
    .clkIn(clkIn), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(rdN), .clkOut(outN));

  function automatic logic [31:0] mkWord(int w, int h, bit byp, bit apply);
    logic [31:0] v = '0;
    v[19:16] = w[3:0];
    v[23:20] = h[3:0];
    v[24] = byp;
    v[25] = apply;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clkIn); #5;
  endtask

  function automatic logic pick(int sel);
    return sel != 0 ? outN : outM;
  endfunction

  task automatic writeCfg(logic [31:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic waitApplied(int sel, string req);
    int n = 0;
    while ((sel != 0 ? rdN[25] : rdM[25]) && n < 100) begin step(); n++; end
    check(req, sel != 0 ? int'(rdN[25]) : int'(rdM[25]), 0);
  endtask

  task automatic measure(int sel, output int hi, output int lo);
    int n = 0;
    while (pick(sel) && n < 80) begin step(); n++; end
    n = 0;
    while (!pick(sel) && n < 80) begin step(); n++; end
    hi = 0;
    while (pick(sel) && hi < 80) begin hi++; step(); end
    lo = 0;
    while (!pick(sel) && lo < 80) begin lo++; step(); end
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int hi, lo, w, h;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clkIn);
    #5 rstN = 1'b1;
    step();
    // R7 reset state
    check("R7 readback", int'(rdM), 0);
    measure(0, hi, lo);
    check("R7 high", hi, 1);
    check("R7 low", lo, 1);

    // R5 apply flag and R2 fields
    writeCfg(mkWord(3, 5, 0, 1));
    check("R5 pending set", int'(rdM[25]), 1);
    waitApplied(0, "R5 pending clear");
    check("R2 wait field", int'(rdM[19:16]), 3);
    check("R2 hold field", int'(rdM[23:20]), 5);
    measure(0, hi, lo);
    check("R1 high 3/5", hi, 4);
    check("R1 low 3/5", lo, 6);

    // R6 write without apply has no effect on period
    writeCfg(mkWord(7, 7, 0, 0));
    check("R6 no pending", int'(rdM[25]), 0);
    measure(0, hi, lo);
    check("R6 high unchanged", hi, 4);
    check("R6 low unchanged", lo, 6);
    writeCfg(mkWord(7, 7, 0, 1));
    waitApplied(0, "R5 pending clear");
    measure(0, hi, lo);
    check("R6 high applied", hi, 8);
    check("R6 low applied", lo, 8);

    // R1 random ratios, odd and even
    for (int i = 0; i < 8; i++) begin
      w = int'($urandom % 16);
      h = int'($urandom % 16);
      writeCfg(mkWord(w, h, 0, 1));
      waitApplied(0, "R5 pending clear");
      measure(0, hi, lo);
      check("R1 random high", hi, w + 1);
      check("R1 random low", lo, h + 1);
    end

    // R1 odd ratio 7 split as wait=2 hold=3
    writeCfg(mkWord(2, 3, 0, 1));
    waitApplied(0, "R5 pending clear");
    measure(0, hi, lo);
    check("R1 odd high", hi, 3);
    check("R1 odd low", lo, 4);

    // R8 maximum ratio, and narrow variant masking
    writeCfg(mkWord(15, 9, 0, 1));
    waitApplied(0, "R5 pending clear");
    waitApplied(1, "R8 narrow pending clear");
    check("R8 narrow wait read", int'(rdN[19:16]), 7);
    check("R8 narrow hold read", int'(rdN[23:20]), 1);
    measure(1, hi, lo);
    check("R8 narrow high", hi, 8);
    check("R8 narrow low", lo, 2);
    writeCfg(mkWord(15, 15, 0, 1));
    waitApplied(0, "R5 pending clear");
    measure(0, hi, lo);
    check("R8 max ratio", hi + lo, 32);
    waitApplied(1, "R8 narrow pending clear");
    measure(1, hi, lo);
    check("R8 narrow max ratio", hi + lo, 16);

    // R3 bypass
    writeCfg(mkWord(15, 15, 1, 0));
    check("R3 bypass readback", int'(rdM[24]), 1);
    repeat (40) step();
    for (int i = 0; i < 4; i++) begin
      check("R3 bypass high half", int'(outM), 1);
      @(negedge clkIn); #5;
      check("R3 bypass low half", int'(outM), 0);
      step();
    end
    // R4 leave bypass, divider resumes
    writeCfg(mkWord(1, 2, 0, 1));
    waitApplied(0, "R5 pending clear");
    repeat (10) step();
    measure(0, hi, lo);
    check("R4 after bypass high", hi, 2);
    check("R4 after bypass low", lo, 3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule